// File: doc/BRIEF.md
# Switch-Stepped Sample Loader and Result Reader

This block is the operator-facing front end of a small four-point transform engine. Two slide switches walk it through a fixed sequence. It first takes four input samples, one per step, from a shared 8-bit data bus. It then starts the transform and waits for it to finish. Finally it presents the four result words on the same bus, one per step. A single seven-segment digit shows the operator which slot is current.

The transform arithmetic is not part of this block. It sees the captured samples on a flat port, receives a one-cycle `fft_start_o` pulse and answers with `fft_done_i`. Its results are read back through `results_i`. The bidirectional pad is split into `bus_in_i`, `bus_out_o` and `bus_oe_o`, so the pad cell lives outside.

Each switch is conditioned before use. It passes through a two-flop synchronizer and a debounce counter, about 10 ms at 50 MHz by default. Only a qualified rising level becomes a single-cycle step.

Top module: `fft_panel_seq`

## Requirements
- R1: After a synchronous active-low reset, `seg_o` is 8'h00 (blank), `bus_oe_o` is 0, `bus_out_o` is 0 and no start pulse is issued.
- R2: A switch level counts only after it has been seen unchanged for `DEBOUNCE_CYC` consecutive cycles behind the synchronizer. A shorter high glitch produces no step. Holding a switch high produces exactly one step.
- R3: Display encoding: bit 0 is segment a through bit 6 is segment g, and bit 7 is the decimal point. Digits 1..8 are 8'h06, 8'h5B, 8'h4F, 8'h66, 8'h6D, 8'h7D, 8'h07 and 8'h7F. A load step while idle enters the load phase at slot 0, shown as digit 1. Slot k of the load phase shows digit k+1.
- R4: In the load phase, each load step captures `bus_in_i` into sample slot k, which is `samples_o[8k+7:8k]`, and then moves to slot k+1.
- R5: The load step that captures the fourth sample produces exactly one cycle of `fft_start_o` and enters a wait state. The wait state shows 8'h80 and ignores both switches until `fft_done_i` is seen.
- R6: On `fft_done_i` the block enters the read phase at slot 0. In slot k of that phase, `bus_oe_o` is 1, `bus_out_o` carries `results_i[8k+7:8k]` and the display shows digit k+5.
- R7: Each read step moves to the next result. The read step taken in the fourth result slot returns the block to idle.
- R8: Steps from the switch that does not own the current phase are ignored. Read steps have no effect in idle, load or wait. Load steps have no effect in wait or read and leave the captured samples unchanged.
- R9: Outside the read phase, `bus_oe_o` is 0 and `bus_out_o` is 0.
- R10: A reset applied in the middle of a sequence returns the block to the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_load_i | input | 1 | Raw load switch, asynchronous |
| sw_read_i | input | 1 | Raw read switch, asynchronous |
| bus_in_i | input | DATA_W | Input side of the shared data pad |
| bus_out_o | output | DATA_W | Output side of the shared data pad |
| bus_oe_o | output | 1 | Pad output enable, high only while reading |
| fft_start_o | output | 1 | One-cycle request to the transform engine |
| fft_done_i | input | 1 | Transform finished |
| samples_o | output | NUM_PTS*DATA_W | Captured samples, slot k at bits 8k+7:8k |
| results_i | input | NUM_PTS*DATA_W | Transform results, word k at bits 8k+7:8k |
| seg_o | output | 8 | Seven-segment pattern, bit 0 = a, bit 7 = point |

## Verification
The bench builds the block with `DEBOUNCE_CYC` set to 4 instead of the 500 000-cycle default. A switch press therefore settles in a few tens of cycles, and full load and read sequences fit in a short run alongside glitch and long-hold presses. `DATA_W` and `NUM_PTS` keep their defaults of 8 and 4, so all eight display digits and all slot wrap points are reached. A modelled transform with an adjustable latency keeps the wait state open long enough to press both switches inside it.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
// fsq_pkg: shared phase type and seven-segment constants for the
// switch-stepped loader. Assumes a common-cathode pattern with bit 0 = a.
package fsq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_WAIT = 2'd2,
        PH_READ = 2'd3
    } phase_e;

    localparam logic [7:0] SEG_BLANK = 8'h00;
    localparam logic [7:0] SEG_WAIT  = 8'h80;

    // Map a decimal digit onto segments a..g (bits 0..6).
    function automatic logic [7:0] seg_digit(input logic [3:0] d);
        logic [7:0] s;
        case (d)
            4'd0:    s = 8'h3F;
            4'd1:    s = 8'h06;
            4'd2:    s = 8'h5B;
            4'd3:    s = 8'h4F;
            4'd4:    s = 8'h66;
            4'd5:    s = 8'h6D;
            4'd6:    s = 8'h7D;
            4'd7:    s = 8'h07;
            4'd8:    s = 8'h7F;
            4'd9:    s = 8'h6F;
            default: s = SEG_BLANK;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fsq_switch_cond.sv
`timescale 1ns/1ps
// fsq_switch_cond: turns one raw, bouncing switch into a single-cycle step.
// Two flops synchronize the level. A counter requires the synchronized
// level to differ from the accepted level for DEBOUNCE_CYC consecutive
// cycles before it is accepted. An accepted 0->1 change emits one pulse.
// Assumes DEBOUNCE_CYC >= 2.
module fsq_switch_cond #(
    parameter int DEBOUNCE_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic step_o
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYC - 1);

    logic             sync1_q, sync2_q, stable_q;
    logic [CNT_W-1:0] cnt_q;

    // Synchronize, time the level change, and pulse on an accepted rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q  <= 1'b0;
            sync2_q  <= 1'b0;
            stable_q <= 1'b0;
            cnt_q    <= '0;
            step_o   <= 1'b0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
            step_o  <= 1'b0;
            if (sync2_q == stable_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
                stable_q <= sync2_q;
                cnt_q    <= '0;
                step_o   <= sync2_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2: a step is never longer than one cycle.
    assert_step_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);
    // R2: a step follows a level the synchronizer still sees high.
    assert_step_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> sync2_q);

endmodule

// File: rtl/fsq_phase_ctrl.sv
`timescale 1ns/1ps
// fsq_phase_ctrl: the phase sequencer. It walks idle -> load (NUM_PTS
// captures) -> wait (transform running) -> read (NUM_PTS results) -> idle.
// It holds the sample slots and the current slot index. Steps from the
// switch that does not own the phase are dropped.
module fsq_phase_ctrl
    import fsq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_PTS = 4,
    localparam int IDX_W  = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_step_i,
    input  logic                      read_step_i,
    input  logic [DATA_W-1:0]         bus_in_i,
    input  logic                      done_i,
    output phase_e                    phase_o,
    output logic [IDX_W-1:0]          idx_o,
    output logic                      start_o,
    output logic [NUM_PTS*DATA_W-1:0] samples_o
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_PTS - 1);

    phase_e            ph_q;
    logic [IDX_W-1:0]  idx_q;
    logic              start_q;
    logic [DATA_W-1:0] smp_q [NUM_PTS];

    // Advance the phase and slot index and capture samples on load steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            idx_q   <= '0;
            start_q <= 1'b0;
            for (int i = 0; i < NUM_PTS; i++) smp_q[i] <= '0;
        end else begin
            start_q <= 1'b0;
            case (ph_q)
                PH_IDLE: if (load_step_i) begin
                    ph_q  <= PH_LOAD;
                    idx_q <= '0;
                end
                PH_LOAD: if (load_step_i) begin
                    smp_q[idx_q] <= bus_in_i;
                    if (idx_q == IDX_LAST) begin
                        ph_q    <= PH_WAIT;
                        idx_q   <= '0;
                        start_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                PH_WAIT: if (done_i) begin
                    ph_q  <= PH_READ;
                    idx_q <= '0;
                end
                PH_READ: if (read_step_i) begin
                    if (idx_q == IDX_LAST) begin
                        ph_q  <= PH_IDLE;
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Flatten the sample slots for the transform engine.
    always_comb begin
        for (int i = 0; i < NUM_PTS; i++) samples_o[i*DATA_W +: DATA_W] = smp_q[i];
    end

    assign phase_o = ph_q;
    assign idx_o   = idx_q;
    assign start_o = start_q;

    // R5: the start request lasts one cycle.
    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    // R5: without done the wait state is held.
    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_WAIT && !done_i) |=> (ph_q == PH_WAIT));
    // R8: samples change only on a load step inside the load phase.
    assert_samples_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_q == PH_LOAD && load_step_i) |=> $stable(samples_o));

endmodule

// File: rtl/fsq_seg_enc.sv
`timescale 1ns/1ps
// fsq_seg_enc: display driver. Load slot k shows digit k+1 and read slot k
// shows digit k+NUM_PTS+1. Idle is blank and wait shows only the point.
// Assumes 2*NUM_PTS <= 9 so that every slot fits one digit.
module fsq_seg_enc
    import fsq_pkg::*;
#(
    parameter int NUM_PTS = 4,
    localparam int IDX_W  = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1
) (
    input  phase_e           phase_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       seg_o
);
    localparam logic [3:0] READ_BASE = 4'(NUM_PTS + 1);

    // Choose the pattern for the current phase and slot.
    always_comb begin
        case (phase_i)
            PH_LOAD: seg_o = seg_digit(4'(idx_i) + 4'd1);
            PH_READ: seg_o = seg_digit(4'(idx_i) + READ_BASE);
            PH_WAIT: seg_o = SEG_WAIT;
            default: seg_o = SEG_BLANK;
        endcase
    end

endmodule

// File: rtl/fft_panel_seq.sv
`timescale 1ns/1ps
// fft_panel_seq: top of the switch-stepped loader and reader. It conditions
// both switches, runs the phase sequencer, steers the split pad bus, and
// drives the display. The pad cell and the transform engine sit outside.
module fft_panel_seq
    import fsq_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int NUM_PTS      = 4,
    parameter int DEBOUNCE_CYC = 500000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sw_load_i,
    input  logic                      sw_read_i,
    input  logic [DATA_W-1:0]         bus_in_i,
    output logic [DATA_W-1:0]         bus_out_o,
    output logic                      bus_oe_o,
    output logic                      fft_start_o,
    input  logic                      fft_done_i,
    output logic [NUM_PTS*DATA_W-1:0] samples_o,
    input  logic [NUM_PTS*DATA_W-1:0] results_i,
    output logic [7:0]                seg_o
);
    localparam int IDX_W = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1;
    localparam int N_SW  = 2;

    logic [N_SW-1:0] sw_raw;
    logic [N_SW-1:0] sw_step;
    phase_e          phase;
    logic [IDX_W-1:0] idx;

    assign sw_raw = {sw_read_i, sw_load_i};

    // One conditioner per switch: bit 0 is load, bit 1 is read.
    for (genvar g = 0; g < N_SW; g++) begin : g_sw
        fsq_switch_cond #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (sw_raw[g]),
            .step_o (sw_step[g])
        );
    end

    fsq_phase_ctrl #(.DATA_W(DATA_W), .NUM_PTS(NUM_PTS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_step_i (sw_step[0]),
        .read_step_i (sw_step[1]),
        .bus_in_i    (bus_in_i),
        .done_i      (fft_done_i),
        .phase_o     (phase),
        .idx_o       (idx),
        .start_o     (fft_start_o),
        .samples_o   (samples_o)
    );

    fsq_seg_enc #(.NUM_PTS(NUM_PTS)) u_seg (
        .phase_i (phase),
        .idx_i   (idx),
        .seg_o   (seg_o)
    );

    // Drive the pad only while reading, with the selected result word.
    always_comb begin
        bus_oe_o  = (phase == PH_READ);
        bus_out_o = bus_oe_o ? results_i[idx*DATA_W +: DATA_W] : '0;
    end

    // R6: the pad driver turns on only after the engine reported done.
    assert_oe_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_o) |-> $past(fft_done_i));
    // R9: the wait display never coincides with a driven pad.
    assert_wait_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_o == SEG_WAIT) |-> !bus_oe_o);
    // R5: the start request never overlaps a driven pad.
    assert_start_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fft_start_o |-> !bus_oe_o);

endmodule

// File: tb/fft_panel_seq_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected panel states into a queue
// and the monitor pops and compares them against the ports.
module fft_panel_seq_tb;
    localparam int DW  = 8;
    localparam int NP  = 4;
    localparam int DEB = 4;

    logic clk = 1'b0, rst_n = 1'b0, sw_load = 1'b0, sw_read = 1'b0;
    logic [DW-1:0] bus_in = '0, bus_out;
    logic bus_oe, fft_start, fft_done = 1'b0;
    logic [NP*DW-1:0] samples, results;
    logic [7:0] seg;

    int errors = 0, checks = 0, start_cnt = 0, fft_delay = 3, fft_cnt = 0;
    logic [DW-1:0] drv [NP];

    typedef struct {
        string      req;
        logic [7:0] seg;
        logic       oe;
        logic [7:0] bus;
    } exp_t;
    exp_t exp_q[$];
    event mon_ev;

    always #10 clk = ~clk;

    fft_panel_seq #(.DATA_W(DW), .NUM_PTS(NP), .DEBOUNCE_CYC(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_load_i(sw_load), .sw_read_i(sw_read),
        .bus_in_i(bus_in), .bus_out_o(bus_out), .bus_oe_o(bus_oe),
        .fft_start_o(fft_start), .fft_done_i(fft_done),
        .samples_o(samples), .results_i(results), .seg_o(seg)
    );

    // Transform stand-in: word k = sample (NP-1-k) + 0x11*(k+1).
    always_comb begin
        for (int k = 0; k < NP; k++)
            results[k*DW +: DW] = samples[(NP-1-k)*DW +: DW] + 8'(8'h11 * (k + 1));
    end

    // Latency model for done, and a count of start cycles.
    always @(posedge clk) begin
        fft_done <= 1'b0;
        if (!rst_n) fft_cnt <= 0;
        else if (fft_start) begin
            fft_cnt   <= fft_delay;
            start_cnt <= start_cnt + 1;
        end else if (fft_cnt != 0) begin
            fft_cnt <= fft_cnt - 1;
            if (fft_cnt == 1) fft_done <= 1'b1;
        end
    end

    function automatic logic [7:0] exp_res(int k);
        return drv[NP-1-k] + 8'(8'h11 * (k + 1));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic expect_panel(input string req, input logic [7:0] s,
                                input logic oe, input logic [7:0] b);
        exp_t e;
        e.req = req; e.seg = s; e.oe = oe; e.bus = b;
        exp_q.push_back(e);
        -> mon_ev;
    endtask

    // Monitor: drain the queue and compare against the outputs.
    initial forever begin
        @(mon_ev);
        while (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(seg == e.seg, e.req, "seg", seg, e.seg);
            check(bus_oe == e.oe, e.req, "oe", bus_oe, e.oe);
            check(bus_out == e.bus, e.req, "bus", bus_out, e.bus);
        end
    end

    task automatic press(input bit rd, input int hold);
        @(negedge clk);
        if (rd) sw_read = 1'b1; else sw_load = 1'b1;
        repeat (hold) @(negedge clk);
        sw_read = 1'b0; sw_load = 1'b0;
        repeat (DEB + 16) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    localparam logic [7:0] D1 = 8'h06, D2 = 8'h5B, D3 = 8'h4F, D4 = 8'h66;
    localparam logic [7:0] D5 = 8'h6D, D6 = 8'h7D, D7 = 8'h07, D8 = 8'h7F;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_panel("R1", 8'h00, 1'b0, 8'h00);
        check(start_cnt == 0, "R1", "start count", start_cnt, 0);

        // R2: a two-cycle glitch is shorter than the debounce window.
        @(negedge clk); sw_load = 1'b1;
        repeat (2) @(negedge clk); sw_load = 1'b0;
        repeat (30) @(negedge clk);
        expect_panel("R2", 8'h00, 1'b0, 8'h00);

        press(1'b1, 20);                         // R8: read step in idle
        expect_panel("R8", 8'h00, 1'b0, 8'h00);
        press(1'b0, 100);                        // R2: long hold, one step
        expect_panel("R3", D1, 1'b0, 8'h00);
        press(1'b1, 20);                         // R8: read step in load
        expect_panel("R8", D1, 1'b0, 8'h00);

        drv[0] = 8'hA0; drv[1] = 8'hB1; drv[2] = 8'hC2; drv[3] = 8'hD3;
        bus_in = drv[0]; press(1'b0, 20);
        expect_panel("R4", D2, 1'b0, 8'h00);
        check(samples[7:0] == drv[0], "R4", "slot0", samples[7:0], drv[0]);
        bus_in = drv[1]; press(1'b0, 20);
        expect_panel("R4", D3, 1'b0, 8'h00);
        bus_in = drv[2]; press(1'b0, 20);
        expect_panel("R4", D4, 1'b0, 8'h00);

        fft_delay = 150;
        bus_in = drv[3]; press(1'b0, 20);
        expect_panel("R5", 8'h80, 1'b0, 8'h00);
        check(start_cnt == 1, "R5", "start cycles", start_cnt, 1);
        for (int k = 0; k < NP; k++)
            check(samples[k*DW +: DW] == drv[k], "R4", "slot", samples[k*DW +: DW], drv[k]);
        press(1'b1, 20);                         // R5/R8: switches ignored in wait
        expect_panel("R8", 8'h80, 1'b0, 8'h00);
        bus_in = 8'h5A; press(1'b0, 20);
        expect_panel("R5", 8'h80, 1'b0, 8'h00);
        check(samples[NP*DW-1 -: DW] == drv[3], "R8", "slot3 kept", samples[NP*DW-1 -: DW], drv[3]);
        repeat (80) @(negedge clk);
        expect_panel("R6", D5, 1'b1, exp_res(0));

        press(1'b0, 20);                         // R8: load step in read
        expect_panel("R8", D5, 1'b1, exp_res(0));
        press(1'b1, 20);
        expect_panel("R7", D6, 1'b1, exp_res(1));
        press(1'b1, 20);
        expect_panel("R7", D7, 1'b1, exp_res(2));
        press(1'b1, 20);
        expect_panel("R6", D8, 1'b1, exp_res(3));
        press(1'b1, 20);
        expect_panel("R9", 8'h00, 1'b0, 8'h00);

        // Second pass with short latency, cut short by a reset.
        fft_delay = 3;
        drv[0] = 8'h01; drv[1] = 8'hFF; drv[2] = 8'h7E; drv[3] = 8'h80;
        press(1'b0, 20);
        for (int k = 0; k < NP; k++) begin
            bus_in = drv[k]; press(1'b0, 20);
        end
        check(start_cnt == 2, "R5", "start cycles", start_cnt, 2);
        expect_panel("R6", D5, 1'b1, exp_res(0));
        press(1'b1, 20);
        expect_panel("R7", D6, 1'b1, exp_res(1));
        do_reset();
        expect_panel("R10", 8'h00, 1'b0, 8'h00);
        press(1'b1, 20);
        expect_panel("R10", 8'h00, 1'b0, 8'h00);

        repeat (2) @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

endmodule